// File: doc/BRIEF.md
# Protected Clock-Multiplier Controller

This block is the digital control side of an on-chip clock multiplier. Software writes an enable/connect word and a multiplier/divider word over a small register bus. Neither word reaches the loop when it is written. Each is held in a staging copy, and the staging copies move into the active registers only when software performs a two-write unlock handshake on a dedicated key register. The active settings drive the loop's enable, multiplier and post-divider controls.

The block also decides which clock the chip runs from. The multiplied clock is selected only when the loop is enabled, connect has been committed, and the lock indication is present. If any of these conditions goes away, the selection falls back at once to the bypass clock. This enforces the software sequence of configure, enable, wait for lock, then connect.

Reset and power-down both leave the loop disabled and bypassed. Only a committed software write can enable the loop again. The analog oscillator is not part of this block; lock arrives as an input.

Top module: `clkmul_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, `loop_en`, `loop_mult`, `loop_div` and `clk_sel` are 0, and every readable register returns 0.
- R2: A write to the control word (address 0) or the settings word (address 1) changes neither the loop outputs nor the readback value until the unlock handshake completes.
- R3: Writing 0xAA to the key register (address 2) arms the handshake. If the next bus write is 0x55 to address 2, the staged words are committed at that clock edge, and the outputs show them after it. Cycles without a write between the two key writes are allowed.
- R4: If the armed handshake is followed by any other write (another address, or another value to address 2), the handshake aborts, the staged words are reset to the active values, and a later correct handshake commits nothing new.
- R5: A write to address 2 of any value other than 0xAA while not armed also resets the staged words to the active values.
- R6: In the settings word, bits [4:0] hold the multiplier minus one (codes 0..31 mean 1..32). Bits [6:5] hold the post-divider code (0..3 mean divide by 2, 4, 8, 16). `loop_mult` and `loop_div` carry the committed codes.
- R7: In the control word, bit 0 is enable and bit 1 is connect. `loop_en` becomes 1 only as the result of a committed handshake, never by itself.
- R8: `clk_sel` is 1 exactly when the committed enable, the committed connect and the lock input are all 1. When lock falls, `clk_sel` drops in the same cycle, with no clock edge needed.
- R9: A connect committed before lock arrives keeps `clk_sel` at 0 until lock rises.
- R10: While `pwr_down` is 1, the committed and staged enable and connect bits are cleared at each clock edge, and a handshake cannot set them. Multiplier and divider codes are kept.
- R11: Readback is combinational. Address 0 returns the active control word in bits [1:0]. Address 1 returns the active settings word in bits [6:0]. Address 3 returns status: multiplier code [4:0], divider code [6:5], enable [7], connect [8], lock [9], clock select [10]. Any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register word address |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rdata | output | DATA_W | Combinational read data for `addr` |
| lock_in | input | 1 | Lock indication from the loop |
| pwr_down | input | 1 | Power-down request, forces bypass |
| loop_en | output | 1 | Committed loop enable |
| loop_mult | output | MULT_W | Committed multiplier code (value minus one) |
| loop_div | output | DIV_W | Committed post-divider code |
| clk_sel | output | 1 | 1 selects the multiplied clock, 0 the bypass clock |

## Verification
The bench builds the block with a 5-bit multiplier field, a 2-bit divider field and zero lock synchroniser stages. With the direct lock path, a lock drop can be observed on `clk_sel` in the same cycle, with no edge in between. The full field widths let the extreme codes 0 and 31 and every divider code be committed and read back. The stimulus table covers the aborted, discarded and gapped handshake orderings.

// File: rtl/clkmul_pkg.sv
`timescale 1ns/1ps
package clkmul_pkg;

   // register word offsets; the key register offset is part of the handshake
   localparam int unsigned OFS_CTRL = 0;
   localparam int unsigned OFS_CFG  = 1;
   localparam int unsigned OFS_KEY  = 2;
   localparam int unsigned OFS_STAT = 3;

   typedef enum logic {
      KEY_IDLE  = 1'b0,
      KEY_ARMED = 1'b1
   } key_state_e;

   // bit 0 enable, bit 1 connect
   typedef struct packed {
      logic connect;
      logic enable;
   } ctrl_t;

endpackage

// File: rtl/clkmul_unlock.sv
`timescale 1ns/1ps
module clkmul_unlock
   import clkmul_pkg::*;
#(
   parameter int unsigned      KEY_W = 8,
   parameter logic [KEY_W-1:0] KEY_A = 'hAA,
   parameter logic [KEY_W-1:0] KEY_B = 'h55
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             hit_key,
   input  logic [KEY_W-1:0] key,
   output logic             commit,
   output logic             discard
);

   key_state_e st_q, st_d;

   always_comb begin
      st_d    = st_q;
      commit  = 1'b0;
      discard = 1'b0;
      if (wr_en) begin
         st_d = KEY_IDLE;
         if (st_q == KEY_ARMED) begin
            if (hit_key && key == KEY_B) commit  = 1'b1;
            else                         discard = 1'b1;
         end else if (hit_key) begin
            if (key == KEY_A) st_d    = KEY_ARMED;
            else              discard = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= KEY_IDLE;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/clkmul_regbank.sv
`timescale 1ns/1ps
module clkmul_regbank
   import clkmul_pkg::*;
#(
   parameter int unsigned MULT_W = 5,
   parameter int unsigned DIV_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_down,
   input  logic              commit,
   input  logic              discard,
   input  logic              wr_ctrl,
   input  logic              wr_cfg,
   input  ctrl_t             ctrl_wr,
   input  logic [MULT_W-1:0] mult_wr,
   input  logic [DIV_W-1:0]  div_wr,
   output ctrl_t             ctrl_act,
   output logic [MULT_W-1:0] mult_act,
   output logic [DIV_W-1:0]  div_act
);

   ctrl_t             stg_ctrl, act_ctrl;
   logic [MULT_W-1:0] stg_mult, act_mult;
   logic [DIV_W-1:0]  stg_div,  act_div;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_ctrl <= '0;
         stg_mult <= '0;
         stg_div  <= '0;
         act_ctrl <= '0;
         act_mult <= '0;
         act_div  <= '0;
      end else begin
         // staging copy: reloaded from the active set on an abort
         if (discard) begin
            stg_ctrl <= act_ctrl;
            stg_mult <= act_mult;
            stg_div  <= act_div;
         end else begin
            if (wr_ctrl) stg_ctrl <= ctrl_wr;
            if (wr_cfg) begin
               stg_mult <= mult_wr;
               stg_div  <= div_wr;
            end
         end
         if (commit) begin
            act_ctrl <= stg_ctrl;
            act_mult <= stg_mult;
            act_div  <= stg_div;
         end
         // power-down wins over any commit in the same cycle
         if (pwr_down) begin
            stg_ctrl <= '0;
            act_ctrl <= '0;
         end
      end
   end

   assign ctrl_act = act_ctrl;
   assign mult_act = act_mult;
   assign div_act  = act_div;

endmodule

// File: rtl/clkmul_clksel.sv
`timescale 1ns/1ps
module clkmul_clksel #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_raw,
   input  logic enable,
   input  logic connect,
   output logic lock_seen,
   output logic sel
);

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         logic unused_clkrst;
         assign unused_clkrst = clk ^ rst_n;
         assign lock_seen     = lock_raw;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= (sh_q << 1) | SYNC_STAGES'(lock_raw);
         end
         assign lock_seen = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   // combinational so a lost lock or cleared enable falls back at once
   assign sel = enable & connect & lock_seen;

endmodule

// File: rtl/clkmul_ctrl.sv
`timescale 1ns/1ps
module clkmul_ctrl
   import clkmul_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned MULT_W      = 5,
   parameter int unsigned DIV_W       = 2,
   parameter int unsigned KEY_W       = 8,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   output logic [DATA_W-1:0] rdata,
   input  logic              lock_in,
   input  logic              pwr_down,
   output logic              loop_en,
   output logic [MULT_W-1:0] loop_mult,
   output logic [DIV_W-1:0]  loop_div,
   output logic              clk_sel
);

   localparam int unsigned CFG_W  = MULT_W + DIV_W;
   localparam int unsigned STAT_W = CFG_W + 4;

   generate
      if (MULT_W < 1 || MULT_W > 8) begin : g_bad_mult
         $error("clkmul_ctrl: MULT_W out of range");
      end
      if (DIV_W < 1 || DIV_W > 4) begin : g_bad_div
         $error("clkmul_ctrl: DIV_W out of range");
      end
      if (DATA_W < STAT_W || DATA_W < KEY_W) begin : g_bad_data
         $error("clkmul_ctrl: DATA_W too narrow");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("clkmul_ctrl: ADDR_W too narrow");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("clkmul_ctrl: SYNC_STAGES too deep");
      end
   endgenerate

   logic hit_ctrl, hit_cfg, hit_key, hit_stat;
   assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
   assign hit_cfg  = (addr == ADDR_W'(OFS_CFG));
   assign hit_key  = (addr == ADDR_W'(OFS_KEY));
   assign hit_stat = (addr == ADDR_W'(OFS_STAT));

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   logic commit, discard;

   clkmul_unlock #(
      .KEY_W (KEY_W)
   ) u_unlock (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .hit_key (hit_key),
      .key     (wdata[KEY_W-1:0]),
      .commit  (commit),
      .discard (discard)
   );

   ctrl_t             ctrl_act;
   logic [MULT_W-1:0] mult_act;
   logic [DIV_W-1:0]  div_act;

   clkmul_regbank #(
      .MULT_W (MULT_W),
      .DIV_W  (DIV_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_down (pwr_down),
      .commit   (commit),
      .discard  (discard),
      .wr_ctrl  (wr_en & hit_ctrl),
      .wr_cfg   (wr_en & hit_cfg),
      .ctrl_wr  (ctrl_t'(wdata[1:0])),
      .mult_wr  (wdata[MULT_W-1:0]),
      .div_wr   (wdata[CFG_W-1:MULT_W]),
      .ctrl_act (ctrl_act),
      .mult_act (mult_act),
      .div_act  (div_act)
   );

   logic lock_seen;

   clkmul_clksel #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .lock_raw  (lock_in),
      .enable    (ctrl_act.enable),
      .connect   (ctrl_act.connect),
      .lock_seen (lock_seen),
      .sel       (clk_sel)
   );

   always_comb begin
      rdata = '0;
      if (hit_ctrl) begin
         rdata[1:0] = ctrl_act;
      end else if (hit_cfg) begin
         rdata[CFG_W-1:0] = {div_act, mult_act};
      end else if (hit_stat) begin
         rdata[STAT_W-1:0] = {clk_sel, lock_seen, ctrl_act.connect,
                              ctrl_act.enable, div_act, mult_act};
      end
   end

   assign loop_en   = ctrl_act.enable;
   assign loop_mult = mult_act;
   assign loop_div  = div_act;

endmodule

// File: rtl/clkmul_ctrl_chk.sv
`timescale 1ns/1ps
module clkmul_ctrl_chk
   import clkmul_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned MULT_W      = 5,
   parameter int unsigned DIV_W       = 2,
   parameter int unsigned SYNC_STAGES = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              wr_en,
   input logic              lock_in,
   input logic              pwr_down,
   input logic              loop_en,
   input logic [MULT_W-1:0] loop_mult,
   input logic [DIV_W-1:0]  loop_div,
   input logic              clk_sel
);

   logic key_b_wr, key_wr;
   assign key_wr   = wr_en && (addr == ADDR_W'(OFS_KEY));
   assign key_b_wr = key_wr && (wdata[7:0] == 8'h55);

   // R2
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !key_b_wr |=> ($stable(loop_mult) && $stable(loop_div)));

   // R7
   en_by_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loop_en) |-> $past(key_wr));

   // R8
   sel_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_sel |-> loop_en);

   // R10
   pdown_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |=> (!loop_en && !clk_sel));

   generate
      if (SYNC_STAGES == 0) begin : g_lock_direct
         // R8
         lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !lock_in |-> !clk_sel);
      end
   endgenerate

endmodule

bind clkmul_ctrl clkmul_ctrl_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .MULT_W      (MULT_W),
   .DIV_W       (DIV_W),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr      (addr),
   .wdata     (wdata),
   .wr_en     (wr_en),
   .lock_in   (lock_in),
   .pwr_down  (pwr_down),
   .loop_en   (loop_en),
   .loop_mult (loop_mult),
   .loop_div  (loop_div),
   .clk_sel   (clk_sel)
);

// File: tb/clkmul_ctrl_bench.sv
`timescale 1ns/1ps
module clkmul_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        wr_en = 1'b0;
   logic [31:0] rdata;
   logic        lock_in = 1'b0;
   logic        pwr_down = 1'b0;
   logic        loop_en;
   logic [4:0]  loop_mult;
   logic [1:0]  loop_div;
   logic        clk_sel;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   clkmul_ctrl #(
      .ADDR_W (4), .DATA_W (32), .MULT_W (5), .DIV_W (2), .SYNC_STAGES (0)
   ) u_clkmul_ctrl (
      .clk (clk), .rst_n (rst_n), .addr (addr), .wdata (wdata), .wr_en (wr_en),
      .rdata (rdata), .lock_in (lock_in), .pwr_down (pwr_down),
      .loop_en (loop_en), .loop_mult (loop_mult), .loop_div (loop_div),
      .clk_sel (clk_sel)
   );

   // fields: addr[21:18] data[17:10] lock[9] en[8] sel[7] mult[6:2] div[1:0]
   localparam int NV = 26;
   localparam logic [21:0] TBL [0:NV-1] = '{
      {4'd1, 8'h45, 1'b0, 1'b0, 1'b0, 5'd0,  2'd0},  // R2 stage cfg
      {4'd2, 8'hAA, 1'b0, 1'b0, 1'b0, 5'd0,  2'd0},
      {4'd2, 8'h55, 1'b0, 1'b0, 1'b0, 5'd5,  2'd2},  // R3 R6 commit
      {4'd0, 8'h01, 1'b0, 1'b0, 1'b0, 5'd5,  2'd2},  // R2
      {4'd2, 8'hAA, 1'b0, 1'b0, 1'b0, 5'd5,  2'd2},
      {4'd2, 8'h55, 1'b0, 1'b1, 1'b0, 5'd5,  2'd2},  // R7 enable
      {4'd0, 8'h03, 1'b0, 1'b1, 1'b0, 5'd5,  2'd2},
      {4'd2, 8'hAA, 1'b1, 1'b1, 1'b0, 5'd5,  2'd2},  // R8 lock, no connect yet
      {4'd2, 8'h55, 1'b1, 1'b1, 1'b1, 5'd5,  2'd2},  // R8 connected
      {4'd1, 8'h7F, 1'b1, 1'b1, 1'b1, 5'd5,  2'd2},
      {4'd2, 8'hAA, 1'b1, 1'b1, 1'b1, 5'd5,  2'd2},
      {4'd0, 8'h00, 1'b1, 1'b1, 1'b1, 5'd5,  2'd2},  // R4 abort by other addr
      {4'd2, 8'hAA, 1'b1, 1'b1, 1'b1, 5'd5,  2'd2},
      {4'd2, 8'h55, 1'b1, 1'b1, 1'b1, 5'd5,  2'd2},  // R4 nothing new
      {4'd1, 8'h60, 1'b1, 1'b1, 1'b1, 5'd5,  2'd2},
      {4'd2, 8'h12, 1'b1, 1'b1, 1'b1, 5'd5,  2'd2},  // R5 bad key idle
      {4'd2, 8'hAA, 1'b1, 1'b1, 1'b1, 5'd5,  2'd2},
      {4'd2, 8'h55, 1'b1, 1'b1, 1'b1, 5'd5,  2'd2},  // R5 nothing new
      {4'd1, 8'h7F, 1'b1, 1'b1, 1'b1, 5'd5,  2'd2},
      {4'd2, 8'hAA, 1'b1, 1'b1, 1'b1, 5'd5,  2'd2},
      {4'd2, 8'h55, 1'b1, 1'b1, 1'b1, 5'd31, 2'd3},  // R6 max code
      {4'd1, 8'h00, 1'b1, 1'b1, 1'b1, 5'd31, 2'd3},
      {4'd2, 8'hAA, 1'b1, 1'b1, 1'b1, 5'd31, 2'd3},
      {4'd5, 8'h00, 1'b1, 1'b1, 1'b1, 5'd31, 2'd3},  // R4 unmapped addr aborts
      {4'd2, 8'hAA, 1'b1, 1'b1, 1'b1, 5'd31, 2'd3},
      {4'd2, 8'h55, 1'b1, 1'b1, 1'b1, 5'd31, 2'd3}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      addr  = a;
      wdata = d;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic unlock();
      bus_write(4'd2, 32'hAA);
      bus_write(4'd2, 32'h55);
   endtask

   task automatic read_reg(input logic [3:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
      end
   end

   initial begin
      logic [31:0] rd;
      // R1 reset state
      #1;
      check("R1 en in reset", {31'd0, loop_en}, 0);
      check("R1 sel in reset", {31'd0, clk_sel}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 mult", {27'd0, loop_mult}, 0);
      check("R1 div", {30'd0, loop_div}, 0);
      read_reg(4'd0, rd); check("R1 ctrl read", rd, 0);
      read_reg(4'd1, rd); check("R1 cfg read", rd, 0);
      read_reg(4'd3, rd); check("R1 status read", rd, 0);

      // table walk: R2 R3 R4 R5 R6 R7 R8
      for (int i = 0; i < NV; i++) begin
         logic [21:0] v;
         v = TBL[i];
         lock_in = v[9];
         bus_write(v[21:18], {24'd0, v[17:10]});
         check($sformatf("R3 row %0d en", i), {31'd0, loop_en}, {31'd0, v[8]});
         check($sformatf("R8 row %0d sel", i), {31'd0, clk_sel}, {31'd0, v[7]});
         check($sformatf("R6 row %0d mult", i), {27'd0, loop_mult}, {27'd0, v[6:2]});
         check($sformatf("R6 row %0d div", i), {30'd0, loop_div}, {30'd0, v[1:0]});
      end

      // R11 readback
      read_reg(4'd0, rd); check("R11 ctrl read", rd, 32'h3);
      read_reg(4'd1, rd); check("R11 cfg read", rd, 32'h7F);
      read_reg(4'd3, rd); check("R11 status read", rd, 32'h7FF);
      read_reg(4'd7, rd); check("R11 unmapped read", rd, 32'h0);

      // R8 same-cycle fallback on lock loss
      lock_in = 1'b0; #1;
      check("R8 lock drop", {31'd0, clk_sel}, 0);
      lock_in = 1'b1; #1;
      check("R8 lock back", {31'd0, clk_sel}, 1);

      // R2 staged value not visible on readback
      bus_write(4'd1, 32'h00);
      read_reg(4'd1, rd); check("R2 staged hidden", rd, 32'h7F);
      // R5 bad key discards it
      bus_write(4'd2, 32'h00);
      unlock();
      check("R5 discard mult", {27'd0, loop_mult}, 31);

      // R10 power-down
      @(negedge clk); pwr_down = 1'b1;
      @(negedge clk);
      check("R10 en cleared", {31'd0, loop_en}, 0);
      check("R10 sel bypass", {31'd0, clk_sel}, 0);
      check("R10 mult kept", {27'd0, loop_mult}, 31);
      bus_write(4'd0, 32'h3);
      unlock();
      check("R10 commit blocked", {31'd0, loop_en}, 0);
      pwr_down = 1'b0;
      unlock();
      check("R7 no auto enable", {31'd0, loop_en}, 0);
      bus_write(4'd0, 32'h1);
      unlock();
      check("R7 sw enable", {31'd0, loop_en}, 1);
      check("R7 no connect", {31'd0, clk_sel}, 0);

      // R3 idle cycles between key writes
      bus_write(4'd1, 32'h21);
      bus_write(4'd2, 32'hAA);
      repeat (3) @(negedge clk);
      bus_write(4'd2, 32'h55);
      check("R3 gap mult", {27'd0, loop_mult}, 1);
      check("R3 gap div", {30'd0, loop_div}, 1);

      // R9 connect before lock
      lock_in = 1'b0;
      bus_write(4'd0, 32'h3);
      unlock();
      check("R9 waits for lock", {31'd0, clk_sel}, 0);
      read_reg(4'd3, rd); check("R9 status", rd, 32'h1A1);
      lock_in = 1'b1; #1;
      check("R9 lock arrives", {31'd0, clk_sel}, 1);

      // R1 reset mid-run
      @(negedge clk); rst_n = 1'b0; #1;
      check("R1 async en", {31'd0, loop_en}, 0);
      check("R1 async sel", {31'd0, clk_sel}, 0);
      check("R1 async mult", {27'd0, loop_mult}, 0);

      done = 1'b1;
      summary();
   end

endmodule